// File: doc/BRIEF.md
# Clock Divider and Timer Prescaler

This block controls the clocking of a small 8-bit microcontroller. It takes the oscillator clock and produces two single-cycle enable strobes. The system enable `sys_en` divides the oscillator rate by a power of two. The timer tick `tick_en` is derived from the system enable through a reloadable 4-bit down counter. Everything runs in the oscillator clock domain. The strobes qualify flops downstream, and no clock is gated.

One 8-bit control register holds both settings. The prescale field sits in bits 7..4 and the divide code in bits 2..0. A plain write strobe loads the register, and the read bus always shows it. The level on `compat_mode` during reset selects one of two sets of defaults.

A new divide code is not used straight away. It is held as a pending value and copied into the active setting only when the free-running 5-bit phase counter wraps to zero. That point is a period boundary for every supported ratio, so the system enable never shows an in-between rate.

Top module: `clk_ctl_unit`

## Requirements
- R1: The control register reads back as {prescale[3:0], 1'b0, divide[2:0]}, with prescale in bits 7..4 and divide in bits 2..0. Bit 3 always reads 0, and writing 1 to bit 3 has no effect.
- R2: When `compat_mode` is 0 during reset, the register resets to 8'h00. `sys_en` is then high on every cycle and `tick_en` is high on every cycle.
- R3: When `compat_mode` is 1 during reset, the register resets to 8'h51 (prescale 5, divide code 1). `sys_en` then pulses every 2 cycles and `tick_en` pulses on every 6th `sys_en` pulse.
- R4: Divide codes 0 to 5 make `sys_en` pulse once every 2^code cycles. Each pulse lasts one cycle, except with code 0, where `sys_en` stays high.
- R5: Divide codes 6 and 7 behave as code 5 (a period of 32 cycles), and the register still reads back the code that was written.
- R6: While the divide setting changes, every interval between `sys_en` pulses equals either the old period or the new period. No other interval appears.
- R7: A new divide code governs `sys_en` no later than 32 cycles after the write.
- R8: `tick_en` pulses once every (prescale + 1) `sys_en` pulses, giving ratios from 1 to 16.
- R9: Writing a new prescale value while a prescale count is in progress leaves that count unchanged. The new value is used from the next reload.
- R10: `tick_en` is high only in cycles where `sys_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| compat_mode | input | 1 | Selects the compatibility defaults when sampled during reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current control register value |
| sys_en | output | 1 | System clock enable strobe |
| tick_en | output | 1 | Timer tick enable strobe |

## Verification
- A wrong phase counter or a wrong active divide code shows on `sys_en` as soon as the next pulse is due. Depending on the setting, that is within one to 32 cycles.
- A switch made at the wrong moment shows up as one interval that matches neither the old period nor the new one.
- A fault in the prescale counter appears at the next `tick_en`. That can take up to 16 system pulses, or 512 cycles at the slowest setting.
- The bench therefore measures pulse intervals across each rewrite, across random settings and across a prescale change made mid-count.

// File: rtl/clk_ctl_unit.sv
module clk_ctl_unit #(
  parameter int PS_W     = 4,
  parameter int DIV_W    = 3,
  parameter int MAX_CODE = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       compat_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sys_en,
  output logic       tick_en
);
  localparam int CNT_W = MAX_CODE;
  localparam int LAG_W = CNT_W + 2;
  localparam logic [PS_W-1:0]  PS_COMPAT  = PS_W'(5);
  localparam logic [DIV_W-1:0] DIV_COMPAT = DIV_W'(1);

  logic [PS_W-1:0]  ps_fld, pcnt;
  logic [DIV_W-1:0] div_fld, div_act;
  logic [CNT_W-1:0] phase, mask;

  function automatic logic [DIV_W-1:0] clamp_code(input logic [DIV_W-1:0] c);
    return (c > DIV_W'(MAX_CODE)) ? DIV_W'(MAX_CODE) : c;
  endfunction

  assign mask    = ~({CNT_W{1'b1}} << div_act);
  assign sys_en  = (phase & mask) == '0;
  assign tick_en = sys_en && (pcnt == '0);
  assign rd_data = {ps_fld, 1'b0, div_fld};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_fld  <= compat_mode ? PS_COMPAT : '0;
      div_fld <= compat_mode ? DIV_COMPAT : '0;
      div_act <= compat_mode ? DIV_COMPAT : '0;
      phase   <= '0;
      pcnt    <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (wr_en) begin
        ps_fld  <= wr_data[7:4];
        div_fld <= wr_data[2:0];
      end
      if (&phase) div_act <= clamp_code(div_fld);
      if (sys_en) pcnt <= (pcnt == '0) ? ps_fld : pcnt - 1'b1;
    end
  end

  logic [LAG_W-1:0] lag;
  always_ff @(posedge clk) begin
    if (!rst_n) lag <= '0;
    else if (div_act == clamp_code(div_fld)) lag <= '0;
    else lag <= lag + 1'b1;
  end

  AST_SWITCH_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_act) |-> phase == '0); // R6
  AST_APPLY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lag <= LAG_W'(1 << CNT_W)); // R7
  AST_TICK_WITH_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |-> sys_en); // R10
  AST_BIT3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] == 1'b0); // R1
  AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    div_act <= DIV_W'(MAX_CODE)); // R5
endmodule

// File: tb/test_clk_ctl_unit.sv
module test_clk_ctl_unit;
  logic clk = 0, rst_n = 0, compat_mode = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic sys_en, tick_en;
  int checks = 0, errors = 0;
  bit done = 0;

  clk_ctl_unit i_clk_ctl_unit (.clk, .rst_n, .compat_mode, .wr_en, .wr_data,
                               .rd_data, .sys_en, .tick_en);

  always #2 clk = ~clk;

  function automatic int exp_period(input int code);
    return 1 << ((code > 5) ? 5 : code);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_reset(input logic cm);
    @(negedge clk); rst_n = 0; compat_mode = cm;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic sys_gap(output int n);
    while (!sys_en) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!sys_en);
  endtask

  task automatic tick_gap(output int k);
    while (!tick_en) @(negedge clk);
    k = 0;
    do begin @(negedge clk); if (sys_en) k++; end while (!tick_en);
  endtask

  int g, k, bad;

  initial begin
    void'($urandom(32'd4711));
    do_reset(0);
    check("R2 reset value", rd_data, 8'h00);
    sys_gap(g); check("R2 sys period", g, 1);
    tick_gap(k); check("R2 tick ratio", k, 1);

    write_reg(8'hFF);
    check("R1 bit3 ignored", rd_data, 8'hF7);
    write_reg(8'h3C);
    check("R1 field layout", rd_data, 8'h34);

    for (int c = 0; c < 8; c++) begin
      write_reg(8'(c));
      repeat (34) @(negedge clk);
      sys_gap(g); check(c > 5 ? "R5 reserved period" : "R4 period", g, exp_period(c));
      sys_gap(g); check("R4 repeat period", g, exp_period(c));
      if (c > 5) check("R5 raw readback", rd_data, c);
    end

    do_reset(1);
    check("R3 reset value", rd_data, 8'h51);
    sys_gap(g); check("R3 sys period", g, 2);
    tick_gap(k); check("R3 tick ratio", k, 6);

    write_reg(8'h03);
    repeat (34) @(negedge clk);
    write_reg(8'h01);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      sys_gap(g);
      if (g != 8 && g != 2) bad++;
    end
    check("R6 no intermediate", bad, 0);
    write_reg(8'h05);
    repeat (32) @(negedge clk);
    sys_gap(g); check("R7 applied within 32", g, 32);

    write_reg(8'hF0);
    tick_gap(k);
    while (!tick_en) @(negedge clk);
    g = 0;
    do begin
      @(negedge clk); g++;
      if (g == 3) begin wr_en = 1; wr_data = 8'h20; end
      if (g == 4) wr_en = 0;
    end while (!tick_en);
    check("R9 count in progress kept", g, 16);
    tick_gap(k); check("R9 new ratio after reload", k, 3);

    for (int it = 0; it < 24; it++) begin
      int c, p, oldp;
      c = $urandom % 8; p = $urandom % 16;
      sys_gap(oldp);
      write_reg({4'(p), 1'b1, 3'(c)});
      bad = 0;
      for (int j = 0; j < 4; j++) begin
        sys_gap(g);
        if (g != oldp && g != exp_period(c)) bad++;
      end
      check("R6 random switch", bad, 0);
      repeat (34) @(negedge clk);
      sys_gap(g); check("R4 random period", g, exp_period(c));
      tick_gap(k); check("R8 random ratio", k, p + 1);
      check("R1 random readback", rd_data, {4'(p), 1'b0, 3'(c)});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk)
    if (rst_n && !done && tick_en && !sys_en) begin
      errors++;
      $display("FAIL R10 tick without sys actual 1 expected 0");
    end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule